// File: doc/BRIEF.md
# Variable-Format Microprogram Sequencer

This block produces the control-memory address of the next microinstruction in a microprogrammed control unit and issues one microinstruction per clock from an internal control store. The top bit of every stored word selects its layout. A control word sends its remaining bits out as datapath control signals, and the next address is either the following address or a microroutine entry point derived from the opcode of the external instruction register. A branch word sends no control signals. It carries a condition selector, an action selector and a target address. The branch logic combines the condition selector with the zero, carry and negative status flags.

The branch actions are jump, microsubroutine call, return, and dispatch on the opcode. A call saves the following address on a four-entry return stack. Calling into a full stack and returning from an empty one both set a sticky error flag. The control store is written through a simple write port, normally while the sequencer is held in reset. Address 0 holds the fetch microroutine, and execution starts there after every reset.

Top module: `useq_top`

## Requirements
- R1: While reset is asserted, and until it has been released internally, `issue_o` is 0 and `upc_o`, `ctrl_o` and `stack_err_o` are 0. The first issued microinstruction after reset is the one at address 0.
- R2: Bit 12 of a stored word selects its format: 0 means control word, 1 means branch word. For an issued control word, `ctrl_o` equals bits 11:0 of the word.
- R3: A control word with bit 11 clear is followed by the word at address `upc_o` + 1.
- R4: A control word with bit 11 set is followed by the word at the mapped address, which is the 4-bit opcode shifted left by two (opcode·4).
- R5: A branch word holds its condition in bits 11:10, its action in bits 9:8 and its target in bits 5:0. While a branch word is issued, `ctrl_o` is all zeros.
- R6: The condition codes are 00 always, 01 zero flag, 10 carry flag and 11 negative flag. When the selected flag is 0 the action is not performed and the next address is `upc_o` + 1.
- R7: Action 00 (jump) continues at the target address.
- R8: Action 01 (call) pushes `upc_o` + 1 and continues at the target. Action 10 (return) pops the newest saved address and continues there.
- R9: Action 11 (dispatch) continues at the opcode-mapped address given in R4.
- R10: The return stack holds 4 entries. A call into a full stack still jumps but discards its return address. A return from an empty stack continues at `upc_o` + 1. Either event sets `stack_err_o`, which stays 1 until the next reset.
- R11: After reset release, a new microinstruction issues on every clock, with `upc_o` giving its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ld_we | input | 1 | Control-store write enable |
| ld_addr | input | 6 | Control-store write address |
| ld_data | input | 13 | Control-store write data |
| opcode | input | 4 | Opcode from the instruction register |
| flag_z | input | 1 | Zero status flag |
| flag_c | input | 1 | Carry status flag |
| flag_n | input | 1 | Negative status flag |
| issue_o | output | 1 | A microinstruction is being issued this cycle |
| upc_o | output | 6 | Address of the issued microinstruction |
| ctrl_o | output | 12 | Control signals of the issued word (zero for branch words) |
| stack_err_o | output | 1 | Sticky return-stack overflow/underflow flag |

## Verification
The assertions assume that the opcode and the status flags stay stable while each word is issued, because they relate the next address to the values of those inputs in the previous cycle. They also assume that the control store is not rewritten while the sequencer runs. The stimulus loads the whole store and sets the opcode and flags only while reset is held, then keeps them fixed for the whole trace of each scenario. Across the scenarios, every condition code, every action, both stack error cases and several mapped entry points are exercised.

// File: rtl/useq_pkg.sv
package useq_pkg;
  typedef enum logic [1:0] {
    COND_ALWAYS = 2'b00,
    COND_ZERO   = 2'b01,
    COND_CARRY  = 2'b10,
    COND_NEG    = 2'b11
  } cond_e;

  typedef enum logic [1:0] {
    ACT_JUMP = 2'b00,
    ACT_CALL = 2'b01,
    ACT_RET  = 2'b10,
    ACT_MAP  = 2'b11
  } act_e;
endpackage

// File: rtl/useq_store.sv
module useq_store #(
  parameter int AW = 6,
  parameter int W  = 13
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/useq_retstack.sv
module useq_retstack #(
  parameter int AW    = 6,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] din,
  output logic [AW-1:0] top,
  output logic          empty,
  output logic          full,
  output logic          err
);
  localparam int CNTW = $clog2(DEPTH + 1);
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            err_q, err_d;
  logic [AW-1:0]   slot [DEPTH];
  logic            push_ok, pop_ok;
  logic [IW-1:0]   top_idx;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNTW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign top_idx = IW'(cnt_q - CNTW'(1));
  assign top     = empty ? '0 : slot[top_idx];
  assign err     = err_q;

  always_comb begin
    cnt_d = cnt_q;
    if (push_ok) begin
      cnt_d = cnt_q + CNTW'(1);
    end else if (pop_ok) begin
      cnt_d = cnt_q - CNTW'(1);
    end
    err_d = err_q | (push && full) | (pop && empty);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      err_q <= err_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push_ok && (cnt_q == CNTW'(g))) begin
        slot[g] <= din;
      end
    end
  end
endmodule

// File: rtl/useq_nextaddr.sv
module useq_nextaddr
  import useq_pkg::*;
#(
  parameter int AW        = 6,
  parameter int CW        = 12,
  parameter int OPW       = 4,
  parameter int MAP_SHIFT = 2
) (
  input  logic [CW:0]    word,
  input  logic [AW-1:0]  upc,
  input  logic [OPW-1:0] opcode,
  input  logic           flag_z,
  input  logic           flag_c,
  input  logic           flag_n,
  input  logic [AW-1:0]  stk_top,
  input  logic           stk_empty,
  output logic [AW-1:0]  nxt,
  output logic           push,
  output logic           pop
);
  localparam int MW = OPW + MAP_SHIFT;

  logic          is_branch;
  logic          map_req;
  cond_e         cond;
  act_e          act;
  logic [AW-1:0] target;
  logic [AW-1:0] seq_addr;
  logic [AW-1:0] map_addr;
  logic [MW-1:0] map_wide;
  logic          taken;

  assign is_branch = word[CW];
  assign map_req   = word[CW-1];
  assign cond      = cond_e'(word[CW-1:CW-2]);
  assign act       = act_e'(word[CW-3:CW-4]);
  assign target    = word[AW-1:0];
  assign seq_addr  = upc + AW'(1);
  assign map_wide  = {opcode, {MAP_SHIFT{1'b0}}};
  assign map_addr  = AW'(map_wide);

  always_comb begin
    unique case (cond)
      COND_ALWAYS: taken = 1'b1;
      COND_ZERO:   taken = flag_z;
      COND_CARRY:  taken = flag_c;
      COND_NEG:    taken = flag_n;
      default:     taken = 1'b0;
    endcase
  end

  always_comb begin
    nxt  = seq_addr;
    push = 1'b0;
    pop  = 1'b0;
    if (!is_branch) begin
      if (map_req) begin
        nxt = map_addr;
      end
    end else if (taken) begin
      unique case (act)
        ACT_JUMP: nxt = target;
        ACT_CALL: begin
          nxt  = target;
          push = 1'b1;
        end
        ACT_RET: begin
          pop = 1'b1;
          nxt = stk_empty ? seq_addr : stk_top;
        end
        ACT_MAP:  nxt = map_addr;
        default:  nxt = seq_addr;
      endcase
    end
  end
endmodule

// File: rtl/useq_top.sv
module useq_top #(
  parameter int AW        = 6,
  parameter int CW        = 12,
  parameter int OPW       = 4,
  parameter int MAP_SHIFT = 2,
  parameter int STK_DEPTH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_we,
  input  logic [AW-1:0]   ld_addr,
  input  logic [CW:0]     ld_data,
  input  logic [OPW-1:0]  opcode,
  input  logic            flag_z,
  input  logic            flag_c,
  input  logic            flag_n,
  output logic            issue_o,
  output logic [AW-1:0]   upc_o,
  output logic [CW-1:0]   ctrl_o,
  output logic            stack_err_o
);
  localparam int W = CW + 1;

  logic [1:0]    sync_q;
  logic          rst_i_n;
  logic          run_q, run_d;
  logic [AW-1:0] upc_q, upc_d;
  logic [W-1:0]  cur_word;
  logic [AW-1:0] br_nxt;
  logic          br_push, br_pop;
  logic [AW-1:0] stk_top;
  logic          stk_empty, stk_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end
  assign rst_i_n = sync_q[1];

  useq_store #(.AW(AW), .W(W)) u_store (
    .clk     (clk),
    .wr_en   (ld_we),
    .wr_addr (ld_addr),
    .wr_data (ld_data),
    .rd_addr (upc_d),
    .rd_data (cur_word)
  );

  useq_nextaddr #(.AW(AW), .CW(CW), .OPW(OPW), .MAP_SHIFT(MAP_SHIFT)) u_next (
    .word      (cur_word),
    .upc       (upc_q),
    .opcode    (opcode),
    .flag_z    (flag_z),
    .flag_c    (flag_c),
    .flag_n    (flag_n),
    .stk_top   (stk_top),
    .stk_empty (stk_empty),
    .nxt       (br_nxt),
    .push      (br_push),
    .pop       (br_pop)
  );

  useq_retstack #(.AW(AW), .DEPTH(STK_DEPTH)) u_stack (
    .clk   (clk),
    .rst_n (rst_i_n),
    .push  (run_q && br_push),
    .pop   (run_q && br_pop),
    .din   (upc_q + AW'(1)),
    .top   (stk_top),
    .empty (stk_empty),
    .full  (stk_full),
    .err   (stack_err_o)
  );

  always_comb begin
    run_d = 1'b1;
    upc_d = run_q ? br_nxt : '0;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      run_q <= 1'b0;
      upc_q <= '0;
    end else begin
      run_q <= run_d;
      upc_q <= upc_d;
    end
  end

  assign issue_o = run_q;
  assign upc_o   = upc_q;
  assign ctrl_o  = (run_q && !cur_word[CW]) ? cur_word[CW-1:0] : '0;
endmodule

// File: rtl/useq_chk.sv
module useq_chk #(
  parameter int AW        = 6,
  parameter int CW        = 12,
  parameter int OPW       = 4,
  parameter int MAP_SHIFT = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           issue,
  input logic [AW-1:0]  upc,
  input logic           err,
  input logic [OPW-1:0] opcode,
  input logic           flag_z,
  input logic [CW:0]    word
);
  logic [OPW+MAP_SHIFT-1:0] map_wide;
  assign map_wide = {opcode, {MAP_SHIFT{1'b0}}};

  // R1
  start_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(issue) |-> (upc == '0));

  // R3
  seq_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !word[CW] && !word[CW-1]) |=> (upc == $past(upc) + AW'(1)));

  // R4
  ctl_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !word[CW] && word[CW-1]) |=> (upc == $past(AW'(map_wide))));

  // R6
  cond_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && word[CW] && (word[CW-1:CW-2] == 2'b01) && !flag_z)
      |=> (upc == $past(upc) + AW'(1)));

  // R7
  jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && word[CW] && (word[CW-1:CW-4] == 4'b0000))
      |=> (upc == $past(word[AW-1:0])));

  // R8
  call_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && word[CW] && (word[CW-1:CW-4] == 4'b0001))
      |=> (upc == $past(word[AW-1:0])));

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  // R11
  issue_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> issue);
endmodule

bind useq_top useq_chk #(.AW(AW), .CW(CW), .OPW(OPW), .MAP_SHIFT(MAP_SHIFT)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .issue  (issue_o),
  .upc    (upc_o),
  .err    (stack_err_o),
  .opcode (opcode),
  .flag_z (flag_z),
  .word   (cur_word)
);

// File: tb/sim_useq_top.sv
`timescale 1ns/1ps
module sim_useq_top;
  localparam int AW = 6;
  localparam int CW = 12;
  localparam int W  = CW + 1;

  typedef struct {
    logic [AW-1:0] upc;
    logic [CW-1:0] ctrl;
    logic          err;
    string         req;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ld_we = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [W-1:0]  ld_data = '0;
  logic [3:0]    opcode = '0;
  logic          flag_z = 1'b0, flag_c = 1'b0, flag_n = 1'b0;
  logic          issue_o;
  logic [AW-1:0] upc_o;
  logic [CW-1:0] ctrl_o;
  logic          stack_err_o;

  exp_t exp_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  int   cycles = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  useq_top u0 (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .opcode(opcode), .flag_z(flag_z), .flag_c(flag_c), .flag_n(flag_n),
    .issue_o(issue_o), .upc_o(upc_o), .ctrl_o(ctrl_o), .stack_err_o(stack_err_o)
  );

  function automatic logic [W-1:0] cw(input logic [CW-1:0] bits);
    return {1'b0, bits};
  endfunction

  function automatic logic [W-1:0] bw(input logic [1:0] cnd, input logic [1:0] act,
                                      input logic [AW-1:0] tgt);
    return {1'b1, cnd, act, 2'b00, tgt};
  endfunction

  task automatic wr(input int a, input logic [W-1:0] d);
    @(negedge clk);
    ld_we = 1'b1; ld_addr = AW'(a); ld_data = d;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic push_exp(input int a, input logic [CW-1:0] c, input logic e, input string r);
    exp_t it;
    it.upc = AW'(a); it.ctrl = c; it.err = e; it.req = r;
    exp_q.push_back(it);
  endtask

  task automatic check_reset(input string r);
    n_cmp++;
    if (issue_o !== 1'b0 || upc_o !== '0 || ctrl_o !== '0 || stack_err_o !== 1'b0) begin
      n_bad++;
      $display("FAIL %s reset: got issue=%b upc=%0d ctrl=%h err=%b, expected 0 0 000 0",
               r, issue_o, upc_o, ctrl_o, stack_err_o);
    end
  endtask

  task automatic run_case(input logic [3:0] op, input logic z, input logic c, input logic n);
    opcode = op; flag_z = z; flag_c = c; flag_n = n;
    @(negedge clk);
    rst_n = 1'b1;
    wait (exp_q.size() == 0);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
  endtask

  // Monitor: pops expected items as words issue
  always @(negedge clk) begin
    if (rst_n && issue_o && exp_q.size() > 0) begin
      exp_t it;
      it = exp_q.pop_front();
      n_cmp++;
      if (upc_o !== it.upc || ctrl_o !== it.ctrl || stack_err_o !== it.err) begin
        n_bad++;
        $display("FAIL %s: got upc=%0d ctrl=%h err=%b, expected upc=%0d ctrl=%h err=%b",
                 it.req, upc_o, ctrl_o, stack_err_o, it.upc, it.ctrl, it.err);
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: got %0d cycles, expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < 64; a++) wr(a, bw(2'b00, 2'b00, '0));
    wr(0,  cw(12'h001));
    wr(1,  cw(12'h802));              // R4 dispatch request
    wr(12, cw(12'h00C));
    wr(13, bw(2'b01, 2'b00, 6'd20));  // R6 branch if zero
    wr(14, bw(2'b00, 2'b01, 6'd30));  // R8 call
    wr(20, bw(2'b10, 2'b00, 6'd40));  // carry
    wr(21, bw(2'b00, 2'b11, 6'd0));   // R9 dispatch
    wr(30, cw(12'h030));
    wr(31, bw(2'b00, 2'b10, 6'd0));   // return
    wr(40, bw(2'b11, 2'b00, 6'd0));   // negative
    wr(48, bw(2'b00, 2'b01, 6'd50));
    wr(50, bw(2'b00, 2'b01, 6'd50));  // R10 overflow loop
    wr(52, bw(2'b00, 2'b10, 6'd0));   // R10 underflow
    wr(60, cw(12'h0FF));
    check_reset("R1");

    // Flags clear: call/return path
    push_exp(0, 12'h001, 0, "R1");  push_exp(1, 12'h802, 0, "R2");
    push_exp(12, 12'h00C, 0, "R4"); push_exp(13, 12'h000, 0, "R3");
    push_exp(14, 12'h000, 0, "R6"); push_exp(30, 12'h000, 0, "R8");
    push_exp(31, 12'h030, 0, "R8"); push_exp(15, 12'h000, 0, "R8");
    push_exp(0, 12'h000, 0, "R7");  push_exp(1, 12'h001, 0, "R11");
    // fix: entries carry ctrl of the word at that address
    exp_q[5].ctrl = 12'h030; exp_q[6].ctrl = 12'h000;
    exp_q[8].ctrl = 12'h001; exp_q[9].ctrl = 12'h802;
    run_case(4'd3, 0, 0, 0);

    // All flags set: zero, carry, negative branches taken
    push_exp(0, 12'h001, 0, "R11"); push_exp(1, 12'h802, 0, "R4");
    push_exp(12, 12'h00C, 0, "R4"); push_exp(13, 12'h000, 0, "R5");
    push_exp(20, 12'h000, 0, "R6"); push_exp(40, 12'h000, 0, "R6");
    push_exp(0, 12'h001, 0, "R6");  push_exp(1, 12'h802, 0, "R11");
    run_case(4'd3, 1, 1, 1);

    // Zero set, carry clear: dispatch from a branch word
    push_exp(0, 12'h001, 0, "R1");  push_exp(1, 12'h802, 0, "R2");
    push_exp(12, 12'h00C, 0, "R4"); push_exp(13, 12'h000, 0, "R6");
    push_exp(20, 12'h000, 0, "R6"); push_exp(21, 12'h000, 0, "R6");
    push_exp(12, 12'h00C, 0, "R9"); push_exp(13, 12'h000, 0, "R5");
    run_case(4'd3, 1, 0, 0);

    // Opcode 5 maps to 20; loops between 20 and 21
    push_exp(0, 12'h001, 0, "R1");  push_exp(1, 12'h802, 0, "R4");
    push_exp(20, 12'h000, 0, "R4"); push_exp(21, 12'h000, 0, "R6");
    push_exp(20, 12'h000, 0, "R9"); push_exp(21, 12'h000, 0, "R9");
    run_case(4'd5, 0, 0, 0);

    // Top opcode 15 maps to 60
    push_exp(0, 12'h001, 0, "R1");  push_exp(1, 12'h802, 0, "R4");
    push_exp(60, 12'h0FF, 0, "R4"); push_exp(61, 12'h000, 0, "R3");
    push_exp(0, 12'h001, 0, "R7");
    run_case(4'd15, 0, 0, 0);

    // Overflow: five calls in a row
    push_exp(0, 12'h001, 0, "R10"); push_exp(1, 12'h802, 0, "R10");
    push_exp(48, 12'h000, 0, "R10"); push_exp(50, 12'h000, 0, "R8");
    push_exp(50, 12'h000, 0, "R10"); push_exp(50, 12'h000, 0, "R10");
    push_exp(50, 12'h000, 0, "R10"); push_exp(50, 12'h000, 1, "R10");
    push_exp(50, 12'h000, 1, "R10");
    run_case(4'd12, 0, 0, 0);
    check_reset("R10");

    // Underflow: return with empty stack
    push_exp(0, 12'h001, 0, "R10"); push_exp(1, 12'h802, 0, "R10");
    push_exp(52, 12'h000, 0, "R10"); push_exp(53, 12'h000, 1, "R10");
    push_exp(0, 12'h001, 1, "R10"); push_exp(1, 12'h802, 1, "R10");
    run_case(4'd13, 0, 0, 0);
    check_reset("R1");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule